// File: doc/BRIEF.md
# Function-Coded Integer ALU

This block is a purely combinational integer arithmetic-logic unit of configurable width (32 bits by default). Two operands and a 3-bit function code go in, and one result word of the operand width comes out in the same cycle. There are no storage elements and no clock.

The code is split into two parts. The top bit decides whether the second operand is used as given or bitwise inverted. That bit also serves as the carry into the single adder, so one adder covers both addition and two's-complement subtraction. The two low bits pick one of four results:
- the bitwise AND of the operands;
- the bitwise OR of the operands;
- the adder sum;
- the adder's top bit, zero-extended, which gives set-less-than.

Carries out of the top bit are dropped. No flags are produced.

Top module: `fcode_alu`

## Requirements
- R1: Code 3'b000 gives result = A & B.
- R2: Code 3'b001 gives result = A | B.
- R3: Code 3'b010 gives result = (A + B) mod 2^WIDTH; the carry out of the top bit is dropped.
- R4: Code 3'b110 gives result = (A + ~B + 1) mod 2^WIDTH, i.e. A − B wrapped to WIDTH bits.
- R5: Code 3'b100 gives result = A & ~B.
- R6: Code 3'b101 gives result = A | ~B.
- R7: Code 3'b111 gives result bit 0 = bit WIDTH−1 of the wrapped A − B, with all higher bits 0. No overflow correction is applied: A=0x7FFFFFFF with B=0x80000000 yields 1, and A=0x80000000 with B=1 yields 0.
- R8: Code 3'b011 gives result bit 0 = bit WIDTH−1 of the wrapped A + B, with all higher bits 0.
- R9: The result depends only on the present inputs. It follows an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand, inverted when func[2] is 1 |
| func | input | 3 | Function code: bit 2 inverts B and sets carry-in; bits 1:0 select the result |
| result | output | WIDTH | Selected result word |

## Verification
Subtraction overflow and set-less-than are two functions that share one adder output: when A − B overflows, the sign that set-less-than reports disagrees with the true signed ordering. The bench provokes this with operand pairs at the extremes of the signed range (most-positive against most-negative, and most-negative against one). It judges the result against the raw wrapped sign bit, not the mathematically correct comparison. The unused code is judged the same way: it must return the zero-extended sign of the sum, including a sum that crosses into the sign bit.

// File: rtl/fcode_alu_pkg.sv
// Package: shared encodings for the function-coded ALU.
// Assumes a 3-bit function code: bit 2 inverts B and sets carry-in,
// bits 1:0 choose the result source.
package fcode_alu_pkg;

    localparam int unsigned FUNC_W = 3;
    localparam int unsigned SEL_W  = 2;
    localparam int unsigned INV_BIT = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_SIGN = 2'b11
    } res_sel_t;

    localparam logic [FUNC_W-1:0] FN_AND    = 3'b000;
    localparam logic [FUNC_W-1:0] FN_OR     = 3'b001;
    localparam logic [FUNC_W-1:0] FN_ADD    = 3'b010;
    localparam logic [FUNC_W-1:0] FN_SPARE  = 3'b011;
    localparam logic [FUNC_W-1:0] FN_ANDN   = 3'b100;
    localparam logic [FUNC_W-1:0] FN_ORN    = 3'b101;
    localparam logic [FUNC_W-1:0] FN_SUB    = 3'b110;
    localparam logic [FUNC_W-1:0] FN_SLT    = 3'b111;

endpackage

// File: rtl/fcode_alu_bcond.sv
// Module: second-operand conditioner.
// Passes B straight through, or inverts every bit when invert is 1.
// Assumes nothing about the operand value; purely combinational.
module fcode_alu_bcond #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic             invert,
    output logic [WIDTH-1:0] b_out
);

    // Per-bit conditional inversion
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            b_out[i] = invert ? ~b_in[i] : b_in[i];
        end
    end

    // Every bit differs from the input exactly when inversion is requested
    always_comb begin
        AST_BCOND_POLARITY: assert ((b_out ^ b_in) == {WIDTH{invert}}) // R5
            else $error("operand conditioner polarity wrong");
    end

endmodule

// File: rtl/fcode_alu_adder.sv
// Module: WIDTH-bit adder with carry-in; the carry out of the top bit is dropped.
// RIPPLE=1 builds an explicit full-adder chain; RIPPLE=0 leaves the
// adder structure to synthesis.
module fcode_alu_adder #(
    parameter int unsigned WIDTH  = 32,
    parameter bit          RIPPLE = 1'b1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum
);

    generate
        if (RIPPLE) begin : g_ripple
            // Bit-serial full-adder chain, carry propagated in a variable
            always_comb begin
                logic cy;
                cy = cin;
                for (int i = 0; i < WIDTH; i++) begin
                    sum[i] = a[i] ^ b[i] ^ cy;
                    cy     = (a[i] & b[i]) | (a[i] & cy) | (b[i] & cy);
                end
            end
        end else begin : g_infer
            // Word-level addition, mapped by synthesis
            always_comb begin
                sum = a + b + {{(WIDTH-1){1'b0}}, cin};
            end
        end
    endgenerate

    // Sum matches the wrapped arithmetic total
    always_comb begin
        AST_ADDER_WRAP: assert (sum == WIDTH'(a + b + {{(WIDTH-1){1'b0}}, cin})) // R3
            else $error("adder sum mismatch");
    end

endmodule

// File: rtl/fcode_alu_resmux.sv
// Module: four-way result select with zero-extended sign source.
// Assumes the sum input is the adder output whose top bit drives the
// set-less-than / spare-code result.
module fcode_alu_resmux
    import fcode_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] and_res,
    input  logic [WIDTH-1:0] or_res,
    input  logic [WIDTH-1:0] sum_res,
    input  res_sel_t         sel,
    output logic [WIDTH-1:0] y
);

    logic [WIDTH-1:0] sign_ext;

    // Place the sum's sign bit at bit 0, clear all others
    always_comb begin
        sign_ext    = '0;
        sign_ext[0] = sum_res[WIDTH-1];
    end

    // Choose the result source
    always_comb begin
        unique case (sel)
            SEL_AND: y = and_res;
            SEL_OR:  y = or_res;
            SEL_SUM: y = sum_res;
            default: y = sign_ext;
        endcase
    end

    // Sign source leaves only bit 0 possibly set, equal to the sum's sign
    always_comb begin
        if (sel == SEL_SIGN) begin
            AST_SIGN_ZEXT: assert ((y >> 1) == '0 && y[0] == sum_res[WIDTH-1]) // R7
                else $error("sign result not zero-extended");
        end
    end

endmodule

// File: rtl/fcode_alu.sv
// Module: top of the function-coded integer ALU.
// Purely combinational. func[2] inverts B and feeds the adder carry-in;
// func[1:0] selects AND / OR / sum / zero-extended sum sign.
// Assumes two's-complement operands; no flags are produced.
module fcode_alu
    import fcode_alu_pkg::*;
#(
    parameter int unsigned WIDTH      = 32,
    parameter bit          RIPPLE_ADD = 1'b1
) (
    input  logic [WIDTH-1:0]  opnd_a,
    input  logic [WIDTH-1:0]  opnd_b,
    input  logic [FUNC_W-1:0] func,
    output logic [WIDTH-1:0]  result
);

    logic             inv_b;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] and_w;
    logic [WIDTH-1:0] or_w;
    logic [WIDTH-1:0] sum_w;
    res_sel_t         sel_w;

    // Decode the function code
    always_comb begin
        inv_b = func[INV_BIT];
        sel_w = res_sel_t'(func[SEL_W-1:0]);
    end

    fcode_alu_bcond #(.WIDTH(WIDTH)) u_bcond (
        .b_in   (opnd_b),
        .invert (inv_b),
        .b_out  (b_eff)
    );

    // Bitwise logic paths on the conditioned operand
    always_comb begin
        and_w = opnd_a & b_eff;
        or_w  = opnd_a | b_eff;
    end

    fcode_alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE_ADD)) u_adder (
        .a   (opnd_a),
        .b   (b_eff),
        .cin (inv_b),
        .sum (sum_w)
    );

    fcode_alu_resmux #(.WIDTH(WIDTH)) u_resmux (
        .and_res (and_w),
        .or_res  (or_w),
        .sum_res (sum_w),
        .sel     (sel_w),
        .y       (result)
    );

    // End-to-end checks of the port behaviour per code
    always_comb begin
        if (func == FN_AND) begin
            AST_AND_PORT: assert (result == (opnd_a & opnd_b)) // R1
                else $error("AND code wrong");
        end
        if (func == FN_OR) begin
            AST_OR_PORT: assert (result == (opnd_a | opnd_b)) // R2
                else $error("OR code wrong");
        end
        if (func == FN_SUB) begin
            AST_SUB_WRAP: assert (result == WIDTH'(opnd_a - opnd_b)) // R4
                else $error("SUB code wrong");
        end
        if (func == FN_ORN) begin
            AST_ORN_PORT: assert (result == (opnd_a | ~opnd_b)) // R6
                else $error("OR-NOT code wrong");
        end
        if (func == FN_SPARE) begin
            AST_SPARE_SIGN: assert ((result >> 1) == '0) // R8
                else $error("spare code not zero-extended");
        end
    end

endmodule

// File: tb/fcode_alu_bench.sv
// Bench: vector table walked by one loop, then directed corner and
// random checks against a behavioural reference model.
module fcode_alu_bench;

    localparam int unsigned W = 32;
    localparam int unsigned NV = 17;
    localparam int unsigned NRAND = 400;

    logic clk;
    logic rst_n;
    logic [W-1:0] a, b;
    logic [2:0]   f;
    logic [W-1:0] y;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    localparam logic [W-1:0] VA [NV] = '{
        32'hF0F0_00FF, 32'hF0F0_00FF, 32'd3, 32'hFFFF_FFFF, 32'd7,
        32'd16, 32'd5, 32'hF0F0_00FF, 32'hF0F0_00FF, 32'd25,
        32'd32, 32'h0000_1234, 32'h7FFF_FFFF, 32'h8000_0000,
        32'h4000_0000, 32'd1, 32'hFFFF_FFFF};
    localparam logic [W-1:0] VB [NV] = '{
        32'h0FF0_0F0F, 32'h0FF0_0F0F, 32'd4, 32'd1, 32'd3,
        32'd31, 32'd7, 32'h0FF0_0F0F, 32'h0FF0_0F0F, 32'd32,
        32'd25, 32'h0000_1234, 32'h8000_0000, 32'd1,
        32'h4000_0000, 32'd2, 32'hFFFF_FFFF};
    localparam logic [2:0] VF [NV] = '{
        3'b000, 3'b001, 3'b010, 3'b010, 3'b110,
        3'b110, 3'b110, 3'b100, 3'b101, 3'b111,
        3'b111, 3'b111, 3'b111, 3'b111,
        3'b011, 3'b011, 3'b110};
    localparam logic [W-1:0] VY [NV] = '{
        32'h00F0_000F, 32'hFFF0_0FFF, 32'd7, 32'd0, 32'd4,
        32'hFFFF_FFF1, 32'hFFFF_FFFE, 32'hF000_00F0, 32'hF0FF_F0FF, 32'd1,
        32'd0, 32'd0, 32'd1, 32'd0,
        32'd1, 32'd0, 32'd0};

    fcode_alu #(.WIDTH(W)) u_fcode_alu (
        .opnd_a (a),
        .opnd_b (b),
        .func   (f),
        .result (y)
    );

    // 50 MHz clock for pacing and the watchdog
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Reference model written from the requirements
    function automatic logic [W-1:0] ref_alu(input logic [W-1:0] ra,
                                             input logic [W-1:0] rb,
                                             input logic [2:0]   rf);
        logic [W-1:0] d;
        case (rf)
            3'b000: return ra & rb;
            3'b001: return ra | rb;
            3'b010: return ra + rb;
            3'b011: begin d = ra + rb; return {{(W-1){1'b0}}, d[W-1]}; end
            3'b100: return ra & ~rb;
            3'b101: return ra | ~rb;
            3'b110: return ra - rb;
            default: begin d = ra - rb; return {{(W-1){1'b0}}, d[W-1]}; end
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] rf);
        case (rf)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b011: return "R8";
            3'b100: return "R5";
            3'b101: return "R6";
            3'b110: return "R4";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] exp);
        n_chk++;
        if (y !== exp) begin
            n_err++;
            $display("FAIL %s: a=%h b=%h f=%b actual=%h expected=%h",
                     req, a, b, f, y, exp);
        end
    endtask

    // Apply on the falling edge, sample a few ns later
    task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb,
                         input logic [2:0] tf);
        @(negedge clk);
        a = ta; b = tb; f = tf;
        #2;
    endtask

    // Watchdog: a hung run counts as a failure and still summarises
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] corners [4];
        corners[0] = '0;
        corners[1] = '1;
        corners[2] = {1'b1, {(W-1){1'b0}}};
        corners[3] = 32'h0000_5A5A;
        rst_n = 1'b0;
        a = '0; b = '0; f = 3'b000;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Reset/idle state: zero operands under AND give zero (R1)
        #2 check("R1", '0);

        // Table walk: R1..R8 including R7 overflow pairs
        for (int i = 0; i < NV; i++) begin
            apply(VA[i], VB[i], VF[i]);
            check(req_of(VF[i]), VY[i]);
        end

        // R9: change inputs with no clock edge; result follows
        @(posedge clk);
        #3;
        a = 32'd100; b = 32'd1; f = 3'b010;
        #1 check("R9", 32'd101);
        f = 3'b110;
        #1 check("R9", 32'd99);
        b = 32'd200;
        #1 check("R9", 32'hFFFF_FF9C);

        // Corner operands, including A equal to B, for every code
        for (int ia = 0; ia < 4; ia++) begin
            for (int ib = 0; ib < 4; ib++) begin
                for (int fc = 0; fc < 8; fc++) begin
                    apply(corners[ia], corners[ib], 3'(fc));
                    check(req_of(3'(fc)), ref_alu(corners[ia], corners[ib], 3'(fc)));
                end
            end
        end

        // Random operands over all codes
        for (int k = 0; k < NRAND; k++) begin
            logic [W-1:0] ra, rb;
            logic [2:0]   rf;
            ra = $urandom;
            rb = $urandom;
            rf = 3'($urandom_range(0, 7));
            apply(ra, rb, rf);
            check(req_of(rf), ref_alu(ra, rb, rf));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule